// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is an 8-bit up-counter for a small controller. It is steered by a control register and reloads from a separate preload register. It has three modes. The first counts edges on an external pin. The second counts a free-running tick at one quarter of the system clock. The third measures how long the external pin stays at one level. When the count passes 0xFF, the counter reloads from the preload register and sends a single-cycle request to an interrupt controller.

Software writes one of two addresses through a simple write strobe. Address 0 is the counter address, and a write there only updates the preload value. Address 1 is the control register. The live count and the control register are always visible on output ports, which serve as the read path.

The external pin is asynchronous. It passes through a two-flop synchroniser, and a third flop then detects its edges. The counter core is a four-state machine:
- STOPPED: no counting.
- COUNTING: event or timer mode.
- ARMED: pulse-width mode, waiting for the start edge.
- MEASURING: pulse-width mode, counting ticks.

The transitions are named as follows:
- go: run set and mode not 00. STOPPED moves to COUNTING, or to ARMED in pulse-width mode.
- halt: run cleared or mode 00. Any state moves to STOPPED.
- remode: the mode changes between event/timer and pulse-width. COUNTING and ARMED/MEASURING move to each other.
- start-edge: ARMED moves to MEASURING.
- return-edge: MEASURING moves to STOPPED and clears run.

Top module: `tmr_evt_counter`

## Requirements
- R1: After reset, the count, the preload value and the control register read 0x00, and the overflow request is low.
- R2: The control register holds these fields:
  - mode in bits 7:6;
  - run in bit 4;
  - edge select in bit 3 (0 = rising, 1 = falling).
  
  Bits 2:0 and bit 5 always read 0, so writing 0xFF reads back 0xD8.
- R3: A write with select 0 (the counter address) changes only the preload value. The live count stays the same.
- R4: In mode 01 with run set, the count rises by one for each selected edge of the external input and ignores the other edge.
- R5: In mode 10 with run set, the count rises by one every 4 system clocks. Any 40 consecutive counting cycles add exactly 10.
- R6: An increment from 0xFF loads the preload value into the count and raises the overflow request for exactly one cycle.
- R7: In mode 11 with run set:
  - The block waits for the selected edge of the external input.
  - It then counts internal ticks while the input stays at the new level.
  - When the input returns to its original level, the run bit clears itself and the count holds.
  
  A 40-cycle pulse adds 10, and a 20-cycle pulse adds 5.
- R8: The count holds while run is 0, and also while the mode is 00 with run set, whatever happens on the external input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle |
| wr_sel | input | 1 | Write target: 0 = counter address (preload), 1 = control |
| wr_data | input | 8 | Write data |
| ext_in | input | 1 | External asynchronous input (events or pulse) |
| count_o | output | 8 | Live counter value |
| ctrl_o | output | 8 | Control register read-back, unused bits zero |
| ovf_o | output | 1 | One-cycle overflow request |

## Verification
The hardest point to reach from the ports is the overflow wrap. The count cannot be written directly, so the only way to 0xFF is a long run of increments. The bench runs timer mode for about a thousand cycles and waits for the request. It then checks that the count equals a preload value written beforehand.

The automatic clearing of run in pulse-width mode also needs an exact input sequence. The bench arms the block first, then holds the pin for a known number of cycles. It places both edges at negative clock edges, so the synchroniser delays cancel and the expected tick count is exact.

// File: rtl/tec_pkg.sv
package tec_pkg;

    typedef enum logic [1:0] {
        MD_OFF = 2'b00,
        MD_EVT = 2'b01,
        MD_TMR = 2'b10,
        MD_PW  = 2'b11
    } tec_mode_e;

    typedef enum logic [1:0] {
        ST_STOPPED   = 2'b00,
        ST_COUNTING  = 2'b01,
        ST_ARMED     = 2'b10,
        ST_MEASURING = 2'b11
    } tec_state_e;

endpackage

// File: rtl/tec_sync.sv
module tec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int LEN = STAGES + 1;

    logic [LEN-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[LEN-2:0], async_i};
    end

    assign level_o = pipe_q[STAGES-1];
    assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    assign fall_o  = ~pipe_q[STAGES-1] & pipe_q[STAGES];
endmodule

// File: rtl/tec_tick.sv
module tec_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);
endmodule

// File: rtl/tmr_evt_counter.sv
module tmr_evt_counter #(
    parameter int WIDTH     = 8,
    parameter int TICK_DIV  = 4,
    parameter int SYNC_FLOPS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ext_in,
    output logic [WIDTH-1:0] count_o,
    output logic [WIDTH-1:0] ctrl_o,
    output logic             ovf_o
);
    import tec_pkg::*;

    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    tec_mode_e  mode_q;
    logic       run_q;
    logic       edge_q;
    tec_state_e state_q, state_d;
    logic [WIDTH-1:0] cnt_q, preload_q;
    logic       ovf_q;

    logic ext_lvl, ext_rise, ext_fall, tick;
    logic act_edge, ret_edge, go, pw, inc, clr_run;
    logic ctrl_wr, pre_wr;

    tec_sync #(.STAGES(SYNC_FLOPS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ext_in),
        .level_o(ext_lvl), .rise_o(ext_rise), .fall_o(ext_fall)
    );

    tec_tick #(.DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    assign ctrl_wr  = wr_en &  wr_sel;
    assign pre_wr   = wr_en & ~wr_sel;
    assign act_edge = edge_q ? ext_fall : ext_rise;
    assign ret_edge = edge_q ? ext_rise : ext_fall;
    assign go       = run_q && (mode_q != MD_OFF);
    assign pw       = (mode_q == MD_PW);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:   if (go) state_d = pw ? ST_ARMED : ST_COUNTING;
            ST_COUNTING:  if (!go) state_d = ST_STOPPED;
                          else if (pw) state_d = ST_ARMED;
            ST_ARMED:     if (!go) state_d = ST_STOPPED;
                          else if (!pw) state_d = ST_COUNTING;
                          else if (act_edge) state_d = ST_MEASURING;
            ST_MEASURING: if (!go) state_d = ST_STOPPED;
                          else if (!pw) state_d = ST_COUNTING;
                          else if (ret_edge) state_d = ST_STOPPED;
            default:      state_d = ST_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // output decode
    always_comb begin
        inc     = 1'b0;
        clr_run = 1'b0;
        unique case (state_q)
            ST_STOPPED:   inc = 1'b0;
            ST_COUNTING:  inc = ((mode_q == MD_EVT) && act_edge) ||
                                ((mode_q == MD_TMR) && tick);
            ST_ARMED:     inc = 1'b0;
            ST_MEASURING: begin
                inc     = go && pw && tick;
                clr_run = go && pw && ret_edge;
            end
            default:      inc = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_OFF;
            run_q  <= 1'b0;
            edge_q <= 1'b0;
        end else if (ctrl_wr) begin
            mode_q <= tec_mode_e'(wr_data[7:6]);
            run_q  <= wr_data[4];
            edge_q <= wr_data[3];
        end else if (clr_run) begin
            run_q  <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      preload_q <= '0;
        else if (pre_wr) preload_q <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (inc && (cnt_q == CNT_MAX)) begin
            cnt_q <= preload_q;
            ovf_q <= 1'b1;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
        end
    end

    assign count_o = cnt_q;
    assign ovf_o   = ovf_q;
    always_comb begin
        ctrl_o      = '0;
        ctrl_o[7:6] = mode_q;
        ctrl_o[4]   = run_q;
        ctrl_o[3]   = edge_q;
    end

    logic unused_lvl;
    assign unused_lvl = ext_lvl;
endmodule

// File: rtl/tec_checker.sv
module tec_checker (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic                wr_sel,
    input logic [7:0]          count_o,
    input logic [7:0]          ctrl_o,
    input logic                ovf_o,
    input logic [7:0]          preload_q,
    input tec_pkg::tec_state_e state_q
);
    import tec_pkg::*;

    AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);                                                // R6

    AST_OVF_FROM_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> ($past(count_o) == 8'hFF));                      // R6

    AST_OVF_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !$past(wr_en && !wr_sel)) |-> (count_o == preload_q)); // R6

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOPPED) |=> $stable(count_o));                    // R8

    AST_RUN_AUTOCLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctrl_o[4]) && !$past(wr_en && wr_sel))
            |-> ($past(state_q) == ST_MEASURING));                        // R7

    AST_ARMED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> $stable(count_o));                      // R7
endmodule

bind tmr_evt_counter tec_checker u_tec_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .count_o(count_o), .ctrl_o(ctrl_o), .ovf_o(ovf_o),
    .preload_q(preload_q), .state_q(state_q)
);

// File: tb/tb_tmr_evt_counter.sv
module tb_tmr_evt_counter;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 5;
    // {control value, pulses, expected count delta}
    localparam logic [15:0] VEC [NVEC] = '{
        {8'h50, 4'd3, 4'd3},   // event, rising
        {8'h58, 4'd2, 4'd2},   // event, falling
        {8'h40, 4'd3, 4'd0},   // event, run off
        {8'h10, 4'd2, 4'd0},   // mode 00 with run
        {8'h58, 4'd4, 4'd4}    // event, falling again
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ext_in = 1'b0;
    logic [7:0] count_o, ctrl_o;
    logic       ovf_o;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_evt_counter dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ext_in(ext_in),
        .count_o(count_o), .ctrl_o(ctrl_o), .ovf_o(ovf_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [7:0] base;
        logic       got;
        idle(2);
        // R1 reset values
        check("R1 count", count_o, 8'h00);
        check("R1 ctrl", ctrl_o, 8'h00);
        check("R1 ovf", ovf_o, 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 count after release", count_o, 8'h00);

        // R2 readback masking
        wr(1'b1, 8'hFF);
        check("R2 readback", ctrl_o, 8'hD8);
        wr(1'b1, 8'h00);
        check("R2 cleared", ctrl_o, 8'h00);

        // R3 preload write leaves count untouched
        base = count_o;
        wr(1'b0, 8'h77);
        idle(3);
        check("R3 count unchanged", count_o, base);

        // R4 / R8 table of event-mode vectors
        for (int i = 0; i < NVEC; i++) begin
            base = count_o;
            wr(1'b1, VEC[i][15:8]);
            idle(4);
            for (int p = 0; p < int'(VEC[i][7:4]); p++) begin
                ext_in = 1'b1; idle(5);
                ext_in = 1'b0; idle(5);
            end
            idle(6);
            check((VEC[i][3:0] == 0) ? "R8 hold" : "R4 event", count_o,
                  int'(base + 8'(VEC[i][3:0])));
        end
        wr(1'b1, 8'h00);

        // R5 timer: 40 counting cycles
        base = count_o;
        wr(1'b1, 8'h90);
        idle(39);
        @(negedge clk); wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h10;
        @(negedge clk); wr_en = 1'b0;
        idle(6);
        check("R5 timer 40 cycles", count_o, int'(base + 8'd10));
        base = count_o;
        idle(20);
        check("R8 mode 00 holds", count_o, base);
        wr(1'b1, 8'h00);

        // R7 pulse-width, rising
        base = count_o;
        wr(1'b1, 8'hD0);
        idle(5);
        check("R7 armed no count", count_o, base);
        ext_in = 1'b1; idle(40);
        ext_in = 1'b0; idle(8);
        check("R7 high width", count_o, int'(base + 8'd10));
        check("R7 run cleared", ctrl_o, 8'hC0);
        base = count_o;
        ext_in = 1'b1; idle(10); ext_in = 1'b0; idle(10);
        check("R8 hold after autoclear", count_o, base);

        // R7 pulse-width, falling
        ext_in = 1'b1; idle(5);
        base = count_o;
        wr(1'b1, 8'hD8);
        idle(5);
        ext_in = 1'b0; idle(20);
        ext_in = 1'b1; idle(8);
        check("R7 low width", count_o, int'(base + 8'd5));
        check("R7 run cleared falling", ctrl_o, 8'hC8);

        // R6 overflow and reload
        wr(1'b0, 8'hF0);
        wr(1'b1, 8'h90);
        got = 1'b0;
        for (int k = 0; k < 1200 && !got; k++) begin
            @(negedge clk);
            if (ovf_o) got = 1'b1;
        end
        check("R6 overflow seen", got, 1);
        check("R6 reload value", count_o, 8'hF0);
        @(negedge clk);
        check("R6 single cycle", ovf_o, 0);
        wr(1'b1, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule